// File: doc/BRIEF.md
# Hibernate Wakeup Filter Controller

This always-on power-management block runs from the slow real-time clock. While the system is running, software programs two durations through a small register interface. The first is the minimum time the wakeup pin, normally the power button, must stay asserted before the system wakes. The second is how long the system reset is held low after the wakeup. Software then issues a hibernate command. The block turns system power off and watches the pin. Only a continuous assertion of the full programmed length restores power. After that the block holds the system reset low for the programmed count and releases it.

Each accepted write to one of the slow-domain registers drops a ready flag for a fixed number of clock cycles, and the register file ignores writes made while the flag is low. Reads are strobed and return data one cycle later. The sequencer has three named states. In `ST_RUN` power is on and reset is released. In `ST_SLEEP` power is off and reset is held. In `ST_WAKE_RST` power is on and reset is held. The transitions are: RUN to SLEEP on an accepted hibernate command; SLEEP to WAKE_RST when the pin filter fires; WAKE_RST to RUN when the reset pulse completes. Each completed wakeup returns to RUN, where a new hibernate command is accepted.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset the block is in ST_RUN with `pwr_en`=1 and `sys_rst_n`=1. The control register reads 0x80 (ready), the filter register reads 0xFFE0 and the reset-count register reads 0x0FE0. Unprogrammed, the filter therefore needs 0xFFE0+1 samples and the reset pulse lasts 4064 cycles.
- R2: Register map and read format. Byte offset 0x00 is control/status, with the ready flag at bit 7; its writes have no effect and do not drop ready. Offset 0x20 is the hibernate command, with the command at bit 0; it reads 0. Offset 0x24 is the filter register, field bits 15:5. Offset 0x28 is the reset-count register, field bits 11:5. Bits outside a field read 0 and ignore writes, and unmapped offsets read 0. `bus_rdata` shows the addressed value on the cycle after the edge that samples `bus_rd`.
- R3: An accepted write to 0x20, 0x24 or 0x28 clears the ready flag for exactly 2 cycles. Reads sampled at the first and second edges after the write see bit 7 = 0, and the read sampled at the third edge sees 1.
- R4: A write to 0x20, 0x24 or 0x28 made while ready is low changes nothing.
- R5: An accepted write to 0x20 with bit 0 = 1 in ST_RUN makes `pwr_en`=0 and `sys_rst_n`=0 from the next cycle. The same write with bit 0 = 0 leaves the outputs unchanged.
- R6: With filter value F (the register's read value), the block wakes at the edge that samples `wake_pin`=1 for the (F+1)th consecutive time in ST_SLEEP. With F=0 it wakes on the first high sample.
- R7: A single low sample of `wake_pin` during ST_SLEEP restarts the count, so F high samples followed by a low sample do not wake the system.
- R8: `wake_pin` has no effect in ST_RUN. Counting starts at the first edge after entering ST_SLEEP, even if the pin was already high.
- R9: After wakeup, `pwr_en`=1 and `sys_rst_n`=0 for max(C,1) cycles, where C is the reset-count read value. Then both are 1.
- R10: After a completed wakeup, a new hibernate command is honoured with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow real-time clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wake_pin | input | 1 | Wakeup pin, active high |
| pwr_en | output | 1 | System power enable, low in hibernation |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench holds the pin high for exactly one sample short of the filter length and then drops it. A filter that failed to clear on the dropout, or that was off by one, would wake there or a cycle away from the expected F+1 samples. It probes the ready flag on each of the three cycles after a write and issues a second write straight after the first. A wrong busy length or a missing write gate shows up as a changed flag read or a changed field value. It also measures the reset pulse at zero, a mid value and the reset-default count, and measures the wake latency with the pin already high at entry. A design that counted during ST_RUN, or that mishandled a zero count, would give a different cycle count.

// File: rtl/hib_pkg.sv
package hib_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_WAKE_RST = 2'd2
    } hib_state_e;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_HIB   = 'h20;
    localparam int OFS_FILT  = 'h24;
    localparam int OFS_RCNT  = 'h28;

    localparam int READY_BIT = 7;
    localparam int HIB_GO_BIT = 0;

endpackage

// File: rtl/hib_regs.sv
module hib_regs
    import hib_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int BUSY_CYC = 2,
    parameter int FILT_W   = 16,
    parameter int FILT_LSB = 5,
    parameter int RCNT_W   = 12,
    parameter int RCNT_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              hib_req,
    output logic [FILT_W-1:0] filt_thr,
    output logic [RCNT_W-1:0] rcnt_len
);

    localparam int BUSY_W = $clog2(BUSY_CYC + 1);
    localparam int FF_W   = FILT_W - FILT_LSB;
    localparam int RF_W   = RCNT_W - RCNT_LSB;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_HIB  = ADDR_W'(OFS_HIB);
    localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(OFS_FILT);
    localparam logic [ADDR_W-1:0] A_RCNT = ADDR_W'(OFS_RCNT);

    logic [BUSY_W-1:0] busy_q;
    logic [FF_W-1:0]   filt_q;
    logic [RF_W-1:0]   rcnt_q;
    logic              ready;
    logic              hit_slow;
    logic              wr_ok;
    logic [DATA_W-1:0] rd_val;
    logic              unused_wdata;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:FILT_W], bus_wdata[FILT_LSB-1:1]};

    assign ready    = (busy_q == '0);
    assign hit_slow = (bus_addr == A_HIB) || (bus_addr == A_FILT) || (bus_addr == A_RCNT);
    assign wr_ok    = bus_wr && ready && hit_slow;
    assign hib_req  = wr_ok && (bus_addr == A_HIB) && bus_wdata[HIB_GO_BIT];

    assign filt_thr = {filt_q, {FILT_LSB{1'b0}}};
    assign rcnt_len = {rcnt_q, {RCNT_LSB{1'b0}}};

    // Write-ready handshake: a countdown started by each accepted write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (wr_ok) begin
            busy_q <= BUSY_W'(BUSY_CYC);
        end else if (!ready) begin
            busy_q <= busy_q - BUSY_W'(1);
        end
    end

    // Field storage; both fields come up at their maximum.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '1;
            rcnt_q <= '1;
        end else if (wr_ok) begin
            if (bus_addr == A_FILT) begin
                filt_q <= bus_wdata[FILT_W-1:FILT_LSB];
            end
            if (bus_addr == A_RCNT) begin
                rcnt_q <= bus_wdata[RCNT_W-1:RCNT_LSB];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (bus_addr)
            A_CTRL:  rd_val[READY_BIT] = ready;
            A_FILT:  rd_val = DATA_W'(filt_thr);
            A_RCNT:  rd_val = DATA_W'(rcnt_len);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_val;
        end
    end

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> !ready);

    // R4
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ready) |=> ($stable(filt_q) && $stable(rcnt_q)));

endmodule

// File: rtl/hib_filter.sv
module hib_filter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pin,
    input  logic [CNT_W-1:0] thr,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;

    // Counts consecutive high samples; any low sample or leaving sleep clears it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || !pin) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign fire = en && pin && (cnt_q >= thr);

    // R7
    continuous_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && thr != '0) |-> $past(pin));

endmodule

// File: rtl/hib_rstgen.sv
module hib_rstgen #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    input  logic             active,
    output logic             done
);

    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= len;
        end else if (active && rem_q > CNT_W'(1)) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    assign done = active && (rem_q <= CNT_W'(1));

    // R9
    done_exits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active);

endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
    import hib_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32,
    parameter int BUSY_CYC = 2,
    parameter int FILT_W   = 16,
    parameter int FILT_LSB = 5,
    parameter int RCNT_W   = 12,
    parameter int RCNT_LSB = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wake_pin,
    output logic              pwr_en,
    output logic              sys_rst_n
);

    hib_state_e        state_q;
    hib_state_e        state_d;
    logic              hib_req;
    logic [FILT_W-1:0] filt_thr;
    logic [RCNT_W-1:0] rcnt_len;
    logic              fire;
    logic              rst_done;
    logic              in_sleep;
    logic              in_wake_rst;

    assign in_sleep    = (state_q == ST_SLEEP);
    assign in_wake_rst = (state_q == ST_WAKE_RST);

    hib_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BUSY_CYC(BUSY_CYC),
        .FILT_W  (FILT_W),
        .FILT_LSB(FILT_LSB),
        .RCNT_W  (RCNT_W),
        .RCNT_LSB(RCNT_LSB)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .hib_req  (hib_req),
        .filt_thr (filt_thr),
        .rcnt_len (rcnt_len)
    );

    hib_filter #(
        .CNT_W(FILT_W)
    ) i_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (in_sleep),
        .pin  (wake_pin),
        .thr  (filt_thr),
        .fire (fire)
    );

    hib_rstgen #(
        .CNT_W(RCNT_W)
    ) i_rstgen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (in_sleep && fire),
        .len   (rcnt_len),
        .active(in_wake_rst),
        .done  (rst_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (hib_req)  state_d = ST_SLEEP;
            ST_SLEEP:    if (fire)     state_d = ST_WAKE_RST;
            ST_WAKE_RST: if (rst_done) state_d = ST_RUN;
            default:                   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pwr_en    = 1'b1;
        sys_rst_n = 1'b1;
        unique case (state_q)
            ST_RUN:      begin pwr_en = 1'b1; sys_rst_n = 1'b1; end
            ST_SLEEP:    begin pwr_en = 1'b0; sys_rst_n = 1'b0; end
            ST_WAKE_RST: begin pwr_en = 1'b1; sys_rst_n = 1'b0; end
            default:     begin pwr_en = 1'b1; sys_rst_n = 1'b1; end
        endcase
    end

    // R5
    pwr_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(hib_req));

    // R9
    pwr_rise_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> !sys_rst_n);

    // R10
    wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_wake_rst |=> (state_q != ST_SLEEP));

    // R6
    sleep_exit_by_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && !fire) |=> in_sleep);

endmodule

// File: tb/test_hib_wake_ctrl.sv
module test_hib_wake_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wake_pin;
    logic        pwr_en;
    logic        sys_rst_n;

    int n_chk = 0;
    int n_err = 0;
    bit ended = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    rd_item_t mon_it;
    logic     rd_d = 1'b0;

    always #5 clk = ~clk;

    hib_wake_ctrl i_hib_wake_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .wake_pin (wake_pin),
        .pwr_en   (pwr_en),
        .sys_rst_n(sys_rst_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Monitor: compares read data against the scoreboard queue.
    always @(posedge clk) rd_d <= bus_rd;

    always @(negedge clk) begin
        if (rd_d) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2 unexpected read", bus_rdata, 32'h0);
            end else begin
                mon_it = sb_q.pop_front();
                chk(bus_rdata == mon_it.exp, mon_it.tag, bus_rdata, mon_it.exp);
            end
        end
    end

    // All driver tasks are entered at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic measure_wake(input int exp_n, input int exp_m, input string rq_f, input string rq_r, input int limit);
        int n = 0;
        int m = 0;
        while (!pwr_en && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, rq_f, n, exp_n);
        while (!sys_rst_n && pwr_en && m < 10000) begin
            m++;
            @(negedge clk);
        end
        chk(m == exp_m, rq_r, m, exp_m);
        chk(pwr_en && sys_rst_n, rq_r, {pwr_en, sys_rst_n}, 2'b11);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0; wake_pin = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(pwr_en && sys_rst_n, "R1 outputs", {pwr_en, sys_rst_n}, 2'b11);
        rd(6'h00, 32'h80,   "R1 ctrl ready");
        rd(6'h24, 32'hFFE0, "R1 filter default");
        rd(6'h28, 32'h0FE0, "R1 reset count default");
        rd(6'h20, 32'h0,    "R2 hibernate reads zero");
        rd(6'h10, 32'h0,    "R2 unmapped reads zero");

        // R2 masking, R3 ready window
        wr(6'h24, 32'hFFFF_00A7);
        rd(6'h00, 32'h0,  "R3 ready low cycle 1");
        rd(6'h00, 32'h0,  "R3 ready low cycle 2");
        rd(6'h00, 32'h80, "R3 ready back");
        rd(6'h24, 32'hA0, "R2 filter masked");

        // R4 write during busy ignored
        wr(6'h28, 32'h0000_F07F);
        wr(6'h24, 32'h0000_004F);
        idle(2);
        rd(6'h24, 32'hA0, "R4 busy write ignored");
        rd(6'h28, 32'h60, "R2 reset count masked");
        wr(6'h24, 32'h0000_004F);
        idle(2);
        rd(6'h24, 32'h40, "R2 filter written");

        // R2 control writes have no effect
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, 32'h80, "R2 ctrl write no effect");

        // R5 hibernate with bit 0 clear
        idle(2);
        wr(6'h20, 32'h2);
        idle(3);
        chk(pwr_en && sys_rst_n, "R5 bit0 clear no sleep", {pwr_en, sys_rst_n}, 2'b11);
        idle(2);

        // R8 pin ignored while running, counted from sleep entry
        wake_pin = 1'b1;
        idle(50);
        chk(pwr_en && sys_rst_n, "R8 pin in run ignored", {pwr_en, sys_rst_n}, 2'b11);
        wr(6'h20, 32'h1);
        chk(!pwr_en && !sys_rst_n, "R5 hibernate entry", {pwr_en, sys_rst_n}, 2'b00);
        measure_wake(65, 96, "R8 wake latency pin high at entry", "R9 reset pulse 96", 1000);
        wake_pin = 1'b0;
        idle(3);

        // R7 dropout one sample short, R10 re-hibernation
        wr(6'h20, 32'h1);
        chk(!pwr_en, "R10 re-hibernate", pwr_en, 1'b0);
        wake_pin = 1'b1;
        idle(64);
        wake_pin = 1'b0;
        idle(1);
        chk(!pwr_en, "R7 short assertion no wake", pwr_en, 1'b0);
        wake_pin = 1'b1;
        measure_wake(65, 96, "R6 filter length 0x40", "R9 reset pulse again", 1000);
        wake_pin = 1'b0;
        idle(3);

        // R6 zero filter, R9 zero reset count
        wr(6'h24, 32'h0);
        idle(2);
        wr(6'h28, 32'h0);
        idle(2);
        wr(6'h20, 32'h1);
        wake_pin = 1'b1;
        measure_wake(1, 1, "R6 zero filter", "R9 zero count pulse", 100);
        wake_pin = 1'b0;
        idle(2);

        // R1 unprogrammed defaults after a fresh reset
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        rd(6'h24, 32'hFFE0, "R1 filter default after reset");
        wr(6'h20, 32'h1);
        wake_pin = 1'b1;
        measure_wake(65505, 4064, "R1 default filter length", "R1 default reset pulse", 70000);
        wake_pin = 1'b0;

        idle(3);
        chk(sb_q.size() == 0, "R2 all reads answered", sb_q.size(), 0);
        summary();
    end

endmodule